// File: doc/BRIEF.md
# Fifteen-Cent Coin Dispenser Controller

This block is the control state machine of a coin-operated dispenser that hands out one item for fifteen cents. One coin slot feeds it: each accepted coin arrives as a single-cycle strobe, either a nickel (5 cents) or a dime (10 cents). The controller keeps the running credit in a two-bit encoded state register. It raises its dispense output for one cycle when the credit has reached fifteen cents or more, and then goes back to zero credit.

The output is a pure function of the stored state (Moore style). A coin therefore shows its effect only after the clock edge that captures it, and the output never follows a coin input combinationally. No change is paid back, so a dime inserted at ten cents of credit still only buys the item and the extra five cents are kept. The upstream coin sensor logic is expected to deliver clean single-cycle strobes.

Top module: `gum_dispense_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low puts the credit at zero (state code 00) whatever the coin inputs are, and `dispense_o` is low in the cycle that follows.
- R2: `dispense_o` is high exactly while the state code is 11 (fifteen cents or more). It depends only on the stored state, so changing the coin inputs between clock edges never changes it.
- R3: A nickel strobe alone moves the credit one step up: 00 (0 cents) to 01 (5 cents), 01 to 10 (10 cents), and 10 to 11. Three nickels from zero therefore raise `dispense_o` after the third capturing edge and not before.
- R4: A dime strobe moves the credit from 00 to 10, and from 01 to 11.
- R5: A dime at 10 cents of credit leads to state 11, the same as a nickel would. The extra nickel is kept and no change is returned.
- R6: In a cycle with no coin strobe, a credit of 0, 5 or 10 cents is held unchanged.
- R7: From state 11, the next clock edge returns the credit to zero. Any coin strobed in that cycle is ignored and adds no credit.
- R8: A cycle with both strobes high is handled as a dime alone.
- R9: `dispense_o` is never high for two clock cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nickel_i | input | 1 | One-cycle strobe: a 5-cent coin was accepted |
| dime_i | input | 1 | One-cycle strobe: a 10-cent coin was accepted |
| dispense_o | output | 1 | High for one cycle to release the item |

## Verification
The block has no parameters because the price, the coin values and the state encoding are fixed, so the bench builds it only in its default form. That single build reaches all four credit states and every coin type from each of them, including the overpaying dime at 10 cents and the both-strobes cycle. The bench also drives coins while the controller is dispensing, to show they are dropped, and toggles the strobes between clock edges to show the output follows only the state.

// File: rtl/vend_pkg.sv
// Package: shared types for the dispenser controller.
// Assumes: credit is stored as a two-bit code; the code values are part of
// the block's behaviour (the dispense decode tests for the top code).
package vend_pkg;

    localparam int CREDIT_W = 2;

    // Stored credit level; the top code means the item is paid for.
    typedef enum logic [CREDIT_W-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_PAID = 2'b11
    } credit_e;

    // Coin seen in the current cycle after priority resolution.
    typedef enum logic [1:0] {
        COIN_NONE   = 2'b00,
        COIN_NICKEL = 2'b01,
        COIN_DIME   = 2'b10
    } coin_e;

endpackage

// File: rtl/vend_coin_decode.sv
// Module: vend_coin_decode
// Turns the two coin strobes into one coin code.
// Assumes: the strobes are synchronous, single-cycle pulses. If both are high
// together, the dime wins.
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);

    // Priority select: dime first, then nickel, else no coin.
    always_comb begin
        if (dime_i) begin
            coin_o = COIN_DIME;
        end else if (nickel_i) begin
            coin_o = COIN_NICKEL;
        end else begin
            coin_o = COIN_NONE;
        end
    end

endmodule

// File: rtl/vend_credit_next.sv
// Module: vend_credit_next
// Next-state function of the credit machine.
// Assumes: the paid state always empties on the next edge and ignores coins;
// overpayment saturates at the paid state.
module vend_credit_next
    import vend_pkg::*;
(
    input  credit_e credit_q,
    input  coin_e   coin_i,
    output credit_e credit_d
);

    // Transition table for each present credit level and coin.
    always_comb begin
        credit_d = credit_q;
        unique case (credit_q)
            CR_ZERO: begin
                if (coin_i == COIN_DIME) begin
                    credit_d = CR_TEN;
                end else if (coin_i == COIN_NICKEL) begin
                    credit_d = CR_FIVE;
                end
            end
            CR_FIVE: begin
                if (coin_i == COIN_DIME) begin
                    credit_d = CR_PAID;
                end else if (coin_i == COIN_NICKEL) begin
                    credit_d = CR_TEN;
                end
            end
            CR_TEN: begin
                if (coin_i != COIN_NONE) begin
                    credit_d = CR_PAID;
                end
            end
            CR_PAID: begin
                credit_d = CR_ZERO;
            end
            default: begin
                credit_d = CR_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/vend_state_reg.sv
// Module: vend_state_reg
// Two-flop credit register with synchronous active-low reset.
// Assumes: reset has priority over any next-state value.
module vend_state_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  credit_e credit_d,
    output credit_e credit_q
);

    // Capture the next credit level, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_q <= CR_ZERO;
        end else begin
            credit_q <= credit_d;
        end
    end

endmodule

// File: rtl/vend_dispense_decode.sv
// Module: vend_dispense_decode
// Moore output decode: release the item while the paid state is held.
// Assumes: the input comes straight from the state register, never from coins.
module vend_dispense_decode
    import vend_pkg::*;
(
    input  credit_e credit_q,
    output logic    dispense_o
);

    // Output from the stored state only.
    always_comb begin
        dispense_o = (credit_q == CR_PAID);
    end

endmodule

// File: rtl/gum_dispense_ctrl.sv
// Module: gum_dispense_ctrl (top)
// Fifteen-cent dispenser controller built from a coin decode, next-state
// logic, a state register and a Moore output decode.
// Assumes: coin strobes are clean one-cycle pulses synchronous to clk.
module gum_dispense_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nickel_i,
    input  logic dime_i,
    output logic dispense_o
);

    coin_e   coin;
    credit_e credit_d;
    credit_e credit_q;

    vend_coin_decode u_coin (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    vend_credit_next u_next (
        .credit_q (credit_q),
        .coin_i   (coin),
        .credit_d (credit_d)
    );

    vend_state_reg u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .credit_d (credit_d),
        .credit_q (credit_q)
    );

    vend_dispense_decode u_out (
        .credit_q   (credit_q),
        .dispense_o (dispense_o)
    );

endmodule

// File: rtl/vend_ctrl_chk.sv
// Module: vend_ctrl_chk
// Assertion checker for gum_dispense_ctrl, attached by bind below.
// Assumes: credit carries the state register's two-bit code.
module vend_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nickel_i,
    input logic       dime_i,
    input logic       dispense_o,
    input logic [1:0] credit
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (credit == 2'b00 && !dispense_o));

    // R2
    dispense_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dispense_o) |-> $past(nickel_i || dime_i));

    // R3
    nickel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nickel_i && !dime_i && credit != 2'b11) |=> credit == $past(credit) + 2'd1);

    // R4
    dime_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dime_i && (credit == 2'b00 || credit == 2'b01)) |=> credit == $past(credit) + 2'd2);

    // R5
    dime_overpay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dime_i && credit == 2'b10) |=> dispense_o);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nickel_i && !dime_i && credit != 2'b11) |=> $stable(credit));

    // R7
    paid_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit == 2'b11) |=> credit == 2'b00);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dispense_o |=> !dispense_o);

endmodule

bind gum_dispense_ctrl vend_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nickel_i   (nickel_i),
    .dime_i     (dime_i),
    .dispense_o (dispense_o),
    .credit     (credit_q)
);

// File: tb/test_gum_dispense_ctrl.sv
module test_gum_dispense_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nickel_i = 1'b0;
    logic dime_i = 1'b0;
    logic dispense_o;

    int checks = 0;
    int failures = 0;

    gum_dispense_ctrl i_gum_dispense_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .nickel_i   (nickel_i),
        .dime_i     (dime_i),
        .dispense_o (dispense_o)
    );

    // 125 MHz clock
    always #4 clk = ~clk;

    task automatic check(input logic exp, input string req);
        checks++;
        if (dispense_o !== exp) begin
            failures++;
            $display("FAIL %s: dispense_o actual=%b expected=%b at %0t", req, dispense_o, exp, $time);
        end
    endtask

    // Present a coin for one edge, then sample after that edge.
    task automatic step(input logic n, input logic d);
        nickel_i = n;
        dime_i   = d;
        @(posedge clk);
        @(negedge clk);
        nickel_i = 1'b0;
        dime_i   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b0, 1'b1);
        check(1'b0, "R1 reset with dime");
        step(1'b1, 1'b0);
        check(1'b0, "R1 reset with nickel");
        rst_n = 1'b1;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        rst_n = 1'b0;
        step(1'b1, 1'b0);
        rst_n = 1'b1;
        check(1'b0, "R1 reset drops credit");
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check(1'b0, "R1 credit restarted at zero");
        step(1'b1, 1'b0);
        check(1'b1, "R1 three nickels after reset");
        step(1'b0, 1'b0);
    endtask

    task automatic t_nickels();
        do_reset();
        step(1'b1, 1'b0);
        check(1'b0, "R3 five cents");
        step(1'b1, 1'b0);
        check(1'b0, "R3 ten cents");
        step(1'b1, 1'b0);
        check(1'b1, "R3 fifteen cents");
        step(1'b0, 1'b0);
        check(1'b0, "R9 one-cycle dispense");
    endtask

    task automatic t_dimes();
        do_reset();
        step(1'b0, 1'b1);
        check(1'b0, "R4 dime from zero");
        step(1'b1, 1'b0);
        check(1'b1, "R4 dime then nickel");
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check(1'b1, "R4 nickel then dime");
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check(1'b1, "R5 dime at ten cents");
        step(1'b0, 1'b0);
        check(1'b0, "R5 no leftover credit");
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check(1'b0, "R5 overpay not carried");
        step(1'b1, 1'b0);
        check(1'b1, "R5 fresh sale");
        step(1'b0, 1'b0);
    endtask

    task automatic t_hold();
        do_reset();
        step(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b0);
            check(1'b0, "R6 idle at five");
        end
        step(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0);
        end
        check(1'b0, "R6 idle at ten");
        step(1'b1, 1'b0);
        check(1'b1, "R6 credit held through idle");
        step(1'b0, 1'b0);
    endtask

    task automatic t_paid_ignore();
        do_reset();
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check(1'b1, "R7 paid");
        step(1'b0, 1'b1);
        check(1'b0, "R7 empty after paid");
        step(1'b1, 1'b0);
        check(1'b0, "R7 dime in paid cycle ignored");
        step(1'b1, 1'b0);
        check(1'b0, "R7 credit at ten");
        step(1'b1, 1'b0);
        check(1'b1, "R7 paid again");
        step(1'b1, 1'b0);
        check(1'b0, "R7 nickel in paid cycle ignored");
        step(1'b0, 1'b1);
        check(1'b0, "R7 dime from zero");
        step(1'b0, 1'b0);
    endtask

    task automatic t_both();
        do_reset();
        step(1'b1, 1'b1);
        check(1'b0, "R8 both strobes");
        step(1'b1, 1'b0);
        check(1'b1, "R8 both counted as dime");
        step(1'b0, 1'b0);
    endtask

    task automatic t_moore();
        do_reset();
        step(1'b0, 1'b1);
        #1 nickel_i = 1'b1;
        #1 checks++;
        if (dispense_o !== 1'b0) begin
            failures++;
            $display("FAIL R2: dispense_o actual=%b expected=0 mid-cycle", dispense_o);
        end
        nickel_i = 1'b0;
        step(1'b0, 1'b0);
        check(1'b0, "R2 pulse between edges not captured");
        step(1'b1, 1'b0);
        check(1'b1, "R2 paid");
        #1 dime_i = 1'b1;
        #1 checks++;
        if (dispense_o !== 1'b1) begin
            failures++;
            $display("FAIL R2: dispense_o actual=%b expected=1 mid-cycle", dispense_o);
        end
        dime_i = 1'b0;
        step(1'b0, 1'b0);
        check(1'b0, "R2 back to zero");
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b0, 1'b0);
        check(1'b0, "R1 reset state");
        t_reset();
        t_nickels();
        t_dimes();
        t_hold();
        t_paid_ignore();
        t_both();
        t_moore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule